// File: doc/BRIEF.md
# GPIO Output Control Bank

This block is the output side of a general-purpose parallel I/O bank. A bus master reaches it through a simple APB-style register interface. For every pin it keeps four bits of state: whether the block drives the pin (output enable), the level to drive (output data), whether a single direct write may change that data bit (direct-write mask), and whether the pin works as an open-drain line.

Output data can be changed in two ways. Set and clear registers, each write-1-to-affect, change individual bits. A direct write to the data register changes every unmasked bit in one access, so a whole parallel bus moves to its new value in one cycle with no intermediate value in between. A pin in open-drain mode is driven only while its data bit is 0 and is released while it is 1. The pad level comes back through a two-stage synchronizer and can be read from a level register.

A bus-phase state machine follows each transfer. It has the states IDLE, SETUP and ACCESS, with these transitions: IDLE to SETUP when the select is raised with enable low (start), SETUP to ACCESS when enable rises (commit), ACCESS to SETUP on a back-to-back start, and ACCESS to IDLE when the select is dropped (release). A write counts only in the enable cycle that directly follows a setup cycle.

Top module: `gpio_out_bank`

## Requirements
- R1: After reset the output-enable, data, mask and open-drain states are all zero, and pad_out and pad_oe are all zero.
- R2: A write to offset 0x0C sets each data bit whose write bit is 1. Data bits written as 0 keep their value.
- R3: A write to offset 0x10 clears each data bit whose write bit is 1. Data bits written as 0 keep their value.
- R4: A write to offset 0x14 replaces only the data bits whose mask bit is 1. Reading 0x14 returns the data.
- R5: The mask is set bit by bit at 0x18 and cleared bit by bit at 0x1C, and reads back at 0x20. Because it resets to zero, a direct write made after reset changes nothing.
- R6: Output enable is set at 0x00, cleared at 0x04 and read back at 0x08. pad_out always equals the data state, whether or not the pin is enabled.
- R7: Open-drain is set at 0x24, cleared at 0x28 and read back at 0x2C. pad_oe[i] is high when the pin is enabled, except when the pin is open-drain and its data bit is 1.
- R8: Offset 0x30 returns pad_in as it was two clock edges earlier.
- R9: The set, clear, enable and disable offsets, unmapped offsets and unaligned addresses all read 0. Writes to status or level offsets change nothing.
- R10: A write is applied only in an enable cycle that directly follows a setup cycle. An enable cycle that does not follow a setup cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus enable (access phase) |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected for a read |
| pad_in | input | 32 | Level seen on each pad |
| pad_out | output | 32 | Value driven to each pad |
| pad_oe | output | 32 | Pad driver enable, per pin |

## Verification
If a state bit is wrong, it shows on pad_out or pad_oe in the cycle right after the write that caused it, because both outputs are combinational functions of the registers. The status reads show the same error within one bus transfer. A fault in the synchronizer or the level path shows only through the level register, and only after two edges. The bench therefore checks that register both one edge and two edges after a pad change. A fault in the bus-phase machine appears as a write that takes effect when it should not, or fails to take effect when it should. A later read of the target register shows this.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } bus_phase_e;

    // Word indices (byte offset / 4)
    localparam int unsigned W_OE_SET   = 0;
    localparam int unsigned W_OE_CLR   = 1;
    localparam int unsigned W_OE_STAT  = 2;
    localparam int unsigned W_DAT_SET  = 3;
    localparam int unsigned W_DAT_CLR  = 4;
    localparam int unsigned W_DAT      = 5;
    localparam int unsigned W_MSK_SET  = 6;
    localparam int unsigned W_MSK_CLR  = 7;
    localparam int unsigned W_MSK_STAT = 8;
    localparam int unsigned W_OD_SET   = 9;
    localparam int unsigned W_OD_CLR   = 10;
    localparam int unsigned W_OD_STAT  = 11;
    localparam int unsigned W_LEVEL    = 12;

endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb,
    output logic rd_en
);

    bus_phase_e phase_q, phase_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        wr_stb  = 1'b0;
        rd_en   = psel && !pwrite;
        unique case (phase_q)
            PH_IDLE: begin
                if (psel && !penable) phase_d = PH_SETUP;     // start
            end
            PH_SETUP: begin
                if (psel && penable) begin                    // commit
                    phase_d = PH_ACCESS;
                    wr_stb  = pwrite;
                end else if (!psel) begin
                    phase_d = PH_IDLE;
                end
            end
            PH_ACCESS: begin
                if (psel && !penable) phase_d = PH_SETUP;     // back-to-back start
                else if (!psel)       phase_d = PH_IDLE;      // release
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // R10
    commit_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(psel && !penable));

endmodule

// File: rtl/gpio_w1_reg.sv
module gpio_w1_reg #(
    parameter int unsigned WIDTH     = 32,
    parameter bit          DIRECT_WR = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic             dir_we,
    input  logic [WIDTH-1:0] dir_mask,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] q_d;
    logic             dir_ok;

    assign dir_ok = dir_we && DIRECT_WR;

    always_comb begin
        q_d = q;
        if (set_we)      q_d = q | wdata;
        else if (clr_we) q_d = q & ~wdata;
        else if (dir_ok) q_d = (q & ~dir_mask) | (wdata & dir_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end

    // R2
    set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((q & $past(wdata)) == $past(wdata)));

    // R3
    clr_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((q & $past(wdata)) == '0));

    // R4
    masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_we && !set_we && !clr_we) |=> (((q ^ $past(q)) & ~$past(dir_mask)) == '0));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic             armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
            armed_q    <= 1'b0;
        end else begin
            stage_q[0] <= din;
            armed_q    <= 1'b1;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];

    // R8
    first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (stage_q[0] == $past(din)));

endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NPINS-1:0]  pwdata,
    output logic [NPINS-1:0]  prdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic             wr_stb, rd_en, aligned;
    logic [IDX_W-1:0] widx;
    logic [NPINS-1:0] oe_q, dat_q, msk_q, od_q, level_q;

    assign widx    = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);

    function automatic logic hit(input logic [IDX_W-1:0] idx, input int unsigned w);
        return idx == IDX_W'(w);
    endfunction

    logic wr_ok;
    assign wr_ok = wr_stb && aligned;

    gpio_bus_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb),
        .rd_en   (rd_en)
    );

    gpio_w1_reg #(.WIDTH(NPINS), .DIRECT_WR(1'b0)) i_oe (
        .clk (clk), .rst_n (rst_n),
        .set_we (wr_ok && hit(widx, W_OE_SET)),
        .clr_we (wr_ok && hit(widx, W_OE_CLR)),
        .dir_we (1'b0), .dir_mask ('0),
        .wdata (pwdata), .q (oe_q)
    );

    gpio_w1_reg #(.WIDTH(NPINS), .DIRECT_WR(1'b1)) i_dat (
        .clk (clk), .rst_n (rst_n),
        .set_we (wr_ok && hit(widx, W_DAT_SET)),
        .clr_we (wr_ok && hit(widx, W_DAT_CLR)),
        .dir_we (wr_ok && hit(widx, W_DAT)), .dir_mask (msk_q),
        .wdata (pwdata), .q (dat_q)
    );

    gpio_w1_reg #(.WIDTH(NPINS), .DIRECT_WR(1'b0)) i_msk (
        .clk (clk), .rst_n (rst_n),
        .set_we (wr_ok && hit(widx, W_MSK_SET)),
        .clr_we (wr_ok && hit(widx, W_MSK_CLR)),
        .dir_we (1'b0), .dir_mask ('0),
        .wdata (pwdata), .q (msk_q)
    );

    gpio_w1_reg #(.WIDTH(NPINS), .DIRECT_WR(1'b0)) i_od (
        .clk (clk), .rst_n (rst_n),
        .set_we (wr_ok && hit(widx, W_OD_SET)),
        .clr_we (wr_ok && hit(widx, W_OD_CLR)),
        .dir_we (1'b0), .dir_mask ('0),
        .wdata (pwdata), .q (od_q)
    );

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) i_sync (
        .clk (clk), .rst_n (rst_n),
        .din (pad_in), .dout (level_q)
    );

    assign pad_out = dat_q;
    assign pad_oe  = oe_q & ~(od_q & dat_q);

    always_comb begin
        prdata = '0;
        if (rd_en && aligned) begin
            if      (hit(widx, W_OE_STAT))  prdata = oe_q;
            else if (hit(widx, W_DAT))      prdata = dat_q;
            else if (hit(widx, W_MSK_STAT)) prdata = msk_q;
            else if (hit(widx, W_OD_STAT))  prdata = od_q;
            else if (hit(widx, W_LEVEL))    prdata = level_q;
        end
    end

    // R5
    masked_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && hit(widx, W_DAT) && msk_q == '0) |=> $stable(pad_out));

    // R7
    od_high_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(od_q) && $stable(oe_q) && $rose(pad_out[0]) && od_q[0] |-> !pad_oe[0]);

endmodule

// File: tb/test_gpio_out_bank.sv
`timescale 1ns/1ps
module test_gpio_out_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata, pad_in, pad_out, pad_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    // Pads: driven value where enabled, pull-up otherwise
    for (genvar b = 0; b < 32; b++) begin : g_pad
        assign pad_in[b] = pad_oe[b] ? pad_out[b] : 1'b1;
    end

    gpio_out_bank i_gpio_out_bank (
        .clk (clk), .rst_n (rst_n),
        .psel (psel), .penable (penable), .pwrite (pwrite),
        .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
        .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h08, 32'h0,        32'h0,        4'd1},  // R1
        '{1'b0, 8'h14, 32'h0,        32'h0,        4'd1},  // R1
        '{1'b0, 8'h20, 32'h0,        32'h0,        4'd5},  // R5
        '{1'b1, 8'h14, 32'hFFFFFFFF, 32'h0,        4'd5},
        '{1'b0, 8'h14, 32'h0,        32'h0,        4'd5},  // R5 blocked
        '{1'b1, 8'h0C, 32'h000000F0, 32'h0,        4'd2},
        '{1'b0, 8'h14, 32'h0,        32'h000000F0, 4'd2},  // R2
        '{1'b1, 8'h0C, 32'h00000003, 32'h0,        4'd2},
        '{1'b0, 8'h14, 32'h0,        32'h000000F3, 4'd2},  // R2
        '{1'b1, 8'h10, 32'h00000030, 32'h0,        4'd3},
        '{1'b0, 8'h14, 32'h0,        32'h000000C3, 4'd3},  // R3
        '{1'b1, 8'h18, 32'h0000FF00, 32'h0,        4'd5},
        '{1'b1, 8'h18, 32'h0000000F, 32'h0,        4'd5},
        '{1'b1, 8'h1C, 32'h00000F00, 32'h0,        4'd5},
        '{1'b0, 8'h20, 32'h0,        32'h0000F00F, 4'd5},  // R5
        '{1'b1, 8'h14, 32'h12345678, 32'h0,        4'd4},
        '{1'b0, 8'h14, 32'h0,        32'h000050C8, 4'd4},  // R4
        '{1'b0, 8'h0C, 32'h0,        32'h0,        4'd9},  // R9
        '{1'b0, 8'h3C, 32'h0,        32'h0,        4'd9},  // R9
        '{1'b1, 8'h08, 32'hFFFFFFFF, 32'h0,        4'd9},
        '{1'b0, 8'h08, 32'h0,        32'h0,        4'd9},  // R9
        '{1'b1, 8'h00, 32'h0000FFFF, 32'h0,        4'd6},
        '{1'b1, 8'h04, 32'h000000FF, 32'h0,        4'd6},
        '{1'b0, 8'h08, 32'h0,        32'h0000FF00, 4'd6},  // R6
        '{1'b1, 8'h24, 32'h0000F000, 32'h0,        4'd7},
        '{1'b1, 8'h28, 32'h00003000, 32'h0,        4'd7},
        '{1'b0, 8'h2C, 32'h0,        32'h0000C000, 4'd7}   // R7
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(pad_out, 32'h0, "R1 pad_out");
        check(pad_oe, 32'h0, "R1 pad_oe");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].data);
            end else begin
                bus_read(VECS[i].addr, rd);
                check(rd, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
            end
        end
        bus_idle();

        // data 50C8, oe FF00, od C000
        #1;
        check(pad_out, 32'h000050C8, "R6 pad_out follows data");
        check(pad_oe, 32'h0000BF00, "R7 open-drain release");

        bus_write(8'h2C, 32'hFFFFFFFF);
        bus_read(8'h2C, rd);
        check(rd, 32'h0000C000, "R9 status write ignored");
        bus_write(8'h30, 32'h00000000);
        bus_read(8'h30, rd);
        check(rd, 32'hFFFF50FF, "R8 level steady");
        bus_read(8'h31, rd);
        check(rd, 32'h0, "R9 unaligned read");

        // Level latency: bit 8 goes high
        bus_write(8'h0C, 32'h00000100);
        bus_read(8'h30, rd);
        check(rd, 32'hFFFF50FF, "R8 one edge after write");
        bus_read(8'h30, rd);
        check(rd, 32'hFFFF51FF, "R8 two edges after write");
        bus_idle();

        // R10: enable cycle without setup
        bus_idle();
        @(negedge clk);
        psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = 8'h0C; pwdata = 32'h00000001;
        bus_idle();
        #1;
        check(pad_out, 32'h000051C8, "R10 stray enable ignored");
        bus_read(8'h14, rd);
        check(rd, 32'h000051C8, "R10 data readback");
        bus_idle();

        // R1 again after mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(pad_out, 32'h0, "R1 pad_out after reset");
        check(pad_oe, 32'h0, "R1 pad_oe after reset");
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(8'h20, rd);
        check(rd, 32'h0, "R1 mask after reset");
        bus_read(8'h2C, rd);
        check(rd, 32'h0, "R1 open-drain after reset");
        bus_idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule